// File: doc/BRIEF.md
# Paged Word Address Pointer

This block holds the byte address that a serial memory slave uses for its next data byte. The pointer is loaded from an 8-bit word address that follows the slave address. It can also take its upper bits, the block-select bits, from the slave address byte alone, so that a read started without a word address still lands in the block the master named. After each byte it advances by a rule that depends on the transfer direction.

In a write, only the four lowest bits count, so a burst stays inside one 16-byte page and wraps back to the start of that page. In a read, the whole pointer counts, crossing page and block edges, and it wraps to zero after the last byte of the array. Between transactions the pointer holds its value, so a read with no address phase continues one past the last byte touched.

The parameter `BLK_BITS` (0 to 3) sets the array size to 256, 512, 1024 or 2048 bytes.

Top module: `wap_word_ptr`

## Requirements
- R1: While `rst_n` is low the pointer is cleared to 0, and it reads 0 in the first cycle after reset is released.
- R2: A cycle with `load_i` high sets the pointer to `blk_i[BLK_BITS-1:0]` in the bits above bit 7 and `word_i` in bits 7..0.
- R3: `load_i` takes priority over `blk_upd_i` and `step_i` in the same cycle.
- R4: A cycle with `step_i` high and `rd_i` low, with no load or block update, adds 1 to pointer bits 3..0 and leaves every bit above bit 3 unchanged.
- R5: In such a write step, low bits 0xF become 0x0 in the same 16-byte page, so a burst of 16 write steps returns the pointer to its start.
- R6: A cycle with `step_i` high and `rd_i` high, with no load or block update, adds 1 to the whole pointer, carrying across page and block edges.
- R7: A read step from the last address of the array (all ones) gives 0.
- R8: With none of `load_i`, `blk_upd_i` or `step_i` high the pointer holds its value.
- R9: A cycle with `blk_upd_i` high and `load_i` low replaces the bits above bit 7 with `blk_i[BLK_BITS-1:0]` and keeps bits 7..0.
- R10: `blk_upd_i` takes priority over `step_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Load full address from `blk_i` and `word_i` |
| blk_upd_i | input | 1 | Replace only the block-select bits from `blk_i` |
| step_i | input | 1 | Advance after a byte |
| rd_i | input | 1 | 1 = read step rule, 0 = write (page) step rule |
| word_i | input | 8 | Word address byte |
| blk_i | input | 3 | Block-select bits from the slave address; bits at and above `BLK_BITS` are unused |
| addr_o | output | 8+BLK_BITS | Current pointer |

## Verification
On every cycle, assertions check that a write step leaves the page bits alone and wraps 0xF to 0x0, that a read step advances the whole pointer and wraps all-ones to zero, that a block update keeps the low byte, that a load takes the composed address, and that an idle cycle holds the pointer. Only the bench scenarios show the pointer value right after reset and the combined priority cases with fixed expected addresses. They also show that a full 16-byte write burst returns to its start and that a sweep of the entire array in read mode comes back to the starting address.

// File: rtl/wap_pkg.sv
package wap_pkg;
  localparam int MAXW   = 11;
  localparam int WORD_W = 8;
  localparam int PAGE_W = 4;

  typedef logic [MAXW-1:0] addr_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_BLK  = 2'd2,
    ACT_LOAD = 2'd3
  } act_e;

  function automatic addr_t width_mask(int aw);
    addr_t m;
    for (int i = 0; i < MAXW; i++) m[i] = (i < aw);
    return m;
  endfunction

  function automatic addr_t join_addr(logic [2:0] blk, logic [7:0] w, int bb);
    return {blk, w} & width_mask(WORD_W + bb);
  endfunction

  function automatic addr_t step_write(addr_t a);
    addr_t r;
    r = a;
    r[PAGE_W-1:0] = a[PAGE_W-1:0] + 4'd1;
    return r;
  endfunction

  function automatic addr_t step_read(addr_t a, int aw);
    return (a + addr_t'(1)) & width_mask(aw);
  endfunction

  function automatic addr_t swap_block(addr_t a, logic [2:0] blk, int bb);
    return {blk, a[WORD_W-1:0]} & width_mask(WORD_W + bb);
  endfunction
endpackage

// File: rtl/wap_arbiter.sv
module wap_arbiter
  import wap_pkg::*;
(
  input  logic load_i,
  input  logic blk_upd_i,
  input  logic step_i,
  output act_e act_o
);
  always_comb begin
    if (load_i)         act_o = ACT_LOAD;
    else if (blk_upd_i) act_o = ACT_BLK;
    else if (step_i)    act_o = ACT_STEP;
    else                act_o = ACT_HOLD;
  end
endmodule

// File: rtl/wap_step.sv
module wap_step
  import wap_pkg::*;
#(
  parameter int BLK_BITS = 3,
  localparam int AW = WORD_W + BLK_BITS
) (
  input  logic [AW-1:0] cur_i,
  input  logic          rd_i,
  input  logic [2:0]    blk_i,
  input  logic [7:0]    word_i,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] load_o,
  output logic [AW-1:0] blk_o,
  output logic          page_wrap_o,
  output logic          array_wrap_o
);
  addr_t cur_w;
  addr_t step_w;
  addr_t load_w;

  always_comb begin
    cur_w  = addr_t'(cur_i);
    step_w = rd_i ? step_read(cur_w, AW) : step_write(cur_w);
    load_w = join_addr(blk_i, word_i, BLK_BITS);
    step_o = step_w[AW-1:0];
    load_o = load_w[AW-1:0];
    page_wrap_o  = !rd_i && (cur_i[PAGE_W-1:0] == '1);
    array_wrap_o = rd_i && (cur_i == '1);
  end

  generate
    if (BLK_BITS == 0) begin : g_no_blk
      assign blk_o = cur_i;
    end else begin : g_blk
      addr_t swap_w;
      always_comb swap_w = swap_block(cur_w, blk_i, BLK_BITS);
      assign blk_o = swap_w[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/wap_reg.sv
module wap_reg
  import wap_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_e          act_i,
  input  logic          rd_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] load_i,
  input  logic [AW-1:0] blk_i,
  input  logic          page_wrap_i,
  input  logic          array_wrap_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] nxt;

  always_comb begin
    unique case (act_i)
      ACT_LOAD: nxt = load_i;
      ACT_BLK:  nxt = blk_i;
      ACT_STEP: nxt = step_i;
      default:  nxt = addr_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_o <= '0;
    else        addr_o <= nxt;
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i == ACT_HOLD |=> $stable(addr_o));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i == ACT_LOAD |=> addr_o == $past(load_i));

  // R4
  wr_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && !rd_i) |=> addr_o[AW-1:PAGE_W] == $past(addr_o[AW-1:PAGE_W]));

  // R5
  wr_page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && page_wrap_i) |=> addr_o[PAGE_W-1:0] == '0);

  // R6
  rd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && rd_i) |=> addr_o == AW'($past(addr_o) + 1'b1));

  // R7
  rd_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && array_wrap_i) |=> addr_o == '0);

  // R9
  blk_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i == ACT_BLK |=> addr_o[WORD_W-1:0] == $past(addr_o[WORD_W-1:0]));
endmodule

// File: rtl/wap_word_ptr.sv
module wap_word_ptr
  import wap_pkg::*;
#(
  parameter int BLK_BITS = 3,
  localparam int ADDR_W = WORD_W + BLK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              blk_upd_i,
  input  logic              step_i,
  input  logic              rd_i,
  input  logic [7:0]        word_i,
  input  logic [2:0]        blk_i,
  output logic [ADDR_W-1:0] addr_o
);
  act_e              act_w;
  logic [ADDR_W-1:0] step_w;
  logic [ADDR_W-1:0] load_w;
  logic [ADDR_W-1:0] blk_w;
  logic              page_wrap_w;
  logic              array_wrap_w;

  wap_arbiter i_arb (
    .load_i    (load_i),
    .blk_upd_i (blk_upd_i),
    .step_i    (step_i),
    .act_o     (act_w)
  );

  wap_step #(.BLK_BITS(BLK_BITS)) i_step (
    .cur_i        (addr_o),
    .rd_i         (rd_i),
    .blk_i        (blk_i),
    .word_i       (word_i),
    .step_o       (step_w),
    .load_o       (load_w),
    .blk_o        (blk_w),
    .page_wrap_o  (page_wrap_w),
    .array_wrap_o (array_wrap_w)
  );

  wap_reg #(.AW(ADDR_W)) i_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (act_w),
    .rd_i         (rd_i),
    .step_i       (step_w),
    .load_i       (load_w),
    .blk_i        (blk_w),
    .page_wrap_i  (page_wrap_w),
    .array_wrap_i (array_wrap_w),
    .addr_o       (addr_o)
  );

  // R3
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (blk_upd_i || step_i)) |=> addr_o[7:0] == $past(word_i));

  // R10
  blk_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_upd_i && step_i && !load_i) |=> addr_o[7:0] == $past(addr_o[7:0]));
endmodule

// File: tb/test_wap_word_ptr.sv
module test_wap_word_ptr;
  localparam int CLK_P = 10;
  localparam int AW    = 11;
  localparam int NVEC  = 17;

  localparam logic [2:0] OP_IDLE = 3'd0, OP_LD = 3'd1, OP_INC = 3'd2, OP_BLK = 3'd3,
                         OP_LDINC = 3'd4, OP_BLKINC = 3'd5, OP_LDBLK = 3'd6;

  // {op, word, blk, rd, expected address}
  localparam logic [25:0] VEC [NVEC] = '{
    {OP_LD,     8'h3E, 3'd5, 1'b0, 11'h53E},  // R2
    {OP_INC,    8'h00, 3'd0, 1'b0, 11'h53F},  // R4
    {OP_INC,    8'h00, 3'd0, 1'b0, 11'h530},  // R5
    {OP_INC,    8'h00, 3'd0, 1'b0, 11'h531},  // R4
    {OP_IDLE,   8'h00, 3'd0, 1'b0, 11'h531},  // R8
    {OP_INC,    8'h00, 3'd0, 1'b1, 11'h532},  // R6
    {OP_LD,     8'hFF, 3'd2, 1'b0, 11'h2FF},  // R2
    {OP_INC,    8'h00, 3'd0, 1'b1, 11'h300},  // R6
    {OP_LD,     8'hFF, 3'd7, 1'b0, 11'h7FF},  // R2
    {OP_INC,    8'h00, 3'd0, 1'b1, 11'h000},  // R7
    {OP_INC,    8'h00, 3'd0, 1'b0, 11'h001},  // R4
    {OP_LDINC,  8'h1F, 3'd1, 1'b0, 11'h11F},  // R3
    {OP_BLK,    8'hAA, 3'd6, 1'b0, 11'h61F},  // R9
    {OP_BLKINC, 8'h55, 3'd0, 1'b1, 11'h01F},  // R10
    {OP_LDBLK,  8'h80, 3'd4, 1'b0, 11'h480},  // R3
    {OP_LD,     8'h7F, 3'd3, 1'b0, 11'h37F},  // R2
    {OP_INC,    8'h00, 3'd0, 1'b0, 11'h370}   // R5
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0, blk_upd_i = 1'b0, step_i = 1'b0, rd_i = 1'b0;
  logic [7:0]    word_i = '0;
  logic [2:0]    blk_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wap_word_ptr #(.BLK_BITS(3)) i_wap_word_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .blk_upd_i(blk_upd_i),
    .step_i(step_i), .rd_i(rd_i), .word_i(word_i), .blk_i(blk_i), .addr_o(addr_o)
  );

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s addr actual %h expected %h", req, addr_o, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [7:0] w, logic [2:0] b, logic r);
    word_i = w; blk_i = b; rd_i = r;
    load_i    = (op == OP_LD) || (op == OP_LDINC) || (op == OP_LDBLK);
    blk_upd_i = (op == OP_BLK) || (op == OP_BLKINC) || (op == OP_LDBLK);
    step_i    = (op == OP_INC) || (op == OP_LDINC) || (op == OP_BLKINC);
    @(posedge clk);
    @(negedge clk);
    load_i = 0; blk_upd_i = 0; step_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [AW-1:0] exp;
    repeat (3) @(negedge clk);
    check("R1", 11'h000);
    rst_n = 1;
    @(negedge clk);
    check("R1", 11'h000);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      apply(v[25:23], v[22:15], v[14:12], v[11]);
      check($sformatf("vector %0d", i), v[10:0]);
    end

    // R8: several idle cycles hold the value
    repeat (5) apply(OP_IDLE, 8'hC3, 3'd7, 1'b1);
    check("R8", 11'h370);

    // R5: a 16-step write burst returns to start, staying in the page
    apply(OP_LD, 8'hA5, 3'd2, 1'b0);
    check("R2", 11'h2A5);
    for (int k = 1; k <= 16; k++) begin
      apply(OP_INC, 8'h00, 3'd0, 1'b0);
      exp = {7'h2A, 4'((5 + k) % 16)};
      check("R5", exp);
    end

    // R6 R7: full array read sweep with wrap to zero
    apply(OP_LD, 8'hF0, 3'd7, 1'b0);
    exp = 11'h7F0;
    for (int k = 0; k < 2048; k++) begin
      apply(OP_INC, 8'h00, 3'd0, 1'b1);
      exp = AW'((int'(exp) + 1) % 2048);
      check(exp == 0 ? "R7" : "R6", exp);
    end
    check("R7", 11'h7F0);

    // R1: reset in mid-run clears the pointer
    apply(OP_LD, 8'h12, 3'd3, 1'b0);
    rst_n = 0;
    #1;
    check("R1", 11'h000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", 11'h000);

    finish_run();
  end
endmodule